// File: doc/BRIEF.md
# Byte-Wide Daisy-Chain Configuration Loader

This block takes configuration data for one device in a chain of devices that share an 8-bit data bus and an externally driven configuration clock. Once the mode pins select byte-wide loading and the init input has been high for two internal-oscillator ticks, the block pulls its status output low. It then takes one whole byte per rising clock edge into a small frame store, as long as its inbound chain-select is high and the store still has room. When the last byte lands, the status output goes high. Wired to the chain-select of the next device, that high hands the shared bus downstream.

Each frame opens with a fixed head byte and closes with a fixed tail byte. A byte in either position that does not match sets a sticky error flag. Frames carry no CRC. The block drives an open-drain done line, pulling it low until its own store is full. It becomes active only once it samples the shared done line high, so every device in a chain starts in the same cycle. A lone device whose done line floats high starts as soon as it is full. The first device in a chain has its chain-select tied high. A program input, active low, restarts the whole load.

Top module: `chain_cfg_loader`

## Requirements
- R1: Loading is enabled only when the mode pins read 3'b010 (bit 2 = 0, bit 1 = 1, bit 0 = 0). With any other value the block never arms, status stays high and no byte is written.
- R2: After program, status_o is high. While init_i is high, osc_tick_i pulses are counted. On the clock edge that samples the second pulse the block arms, and status_o reads low from that edge on. If init_i is low at an edge, the count restarts from zero.
- R3: A byte is stored only on an edge where the block is armed, sel_i is high and the store is not full. Bytes presented with sel_i low are dropped.
- R4: The first edge that meets the R3 conditions after program stores nothing (it is the setup edge). Every later such edge stores data_i at the next address, starting from address 0. rd_data_o shows the store word at rd_addr_i without delay.
- R5: After FRAMES*FRAME_BYTES bytes have been stored the store is full. status_o returns high, and further bytes leave the store unchanged.
- R6: A stored byte at frame position 0 (address mod FRAME_BYTES) that differs from HEAD_BYTE (8'hA5), or at position FRAME_BYTES-1 that differs from TAIL_BYTE (8'h5A), sets frame_err_o on the next edge. frame_err_o stays set until program.
- R7: done_low_o (1 = pull the shared line low) is high from program until the store is full, and low once it is full.
- R8: active_o rises on the edge after one where the store is full and done_i is high. It waits while done_i is low and stays high until program.
- R9: prog_n low at an edge clears the arming state, the write address, the full flag, the setup-edge flag, frame_err_o and active_o. The store contents are kept.
- R10: done_pu_en_o reflects the DONE_PULLUP parameter (default 1, pull-up enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External configuration clock |
| prog_n | input | 1 | Program/restart, active low, synchronous |
| mode_i | input | 3 | Mode pins; 3'b010 selects byte-wide loading |
| init_i | input | 1 | Init level; must be high for arming |
| osc_tick_i | input | 1 | One-cycle strobe per internal-oscillator cycle |
| sel_i | input | 1 | Inbound chain-select (previous device's status) |
| data_i | input | 8 | Shared configuration data byte |
| done_i | input | 1 | Sampled level of the shared done line |
| rd_addr_i | input | AW | Store read address |
| rd_data_o | output | 8 | Store read data |
| status_o | output | 1 | Outbound status, low while this device loads |
| done_low_o | output | 1 | 1 = pull shared done line low |
| done_pu_en_o | output | 1 | Done-line pull-up enable |
| active_o | output | 1 | Device active |
| frame_err_o | output | 1 | Sticky constant-field error |

## Verification
The bench goes after the setup edge. A loader that wrote on it would shift every byte down one address and raise a false frame error. It lets init fall between oscillator ticks, which catches a counter that does not restart and arms one tick early. It drops chain-select in the middle of a frame, where a design that re-primed or kept writing would lose or gain bytes. It also keeps feeding bytes after the store is full, where an off-by-one full flag would overwrite address 0 or the last word. It holds done low after fill, which exposes activation that ignores the shared line, and it corrupts a tail byte, which a checker keyed to the wrong frame position would miss.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam logic [2:0] MODE_BYTEWIDE = 3'b010;

  function automatic logic mode_ok(input logic [2:0] m);
    return m == MODE_BYTEWIDE;
  endfunction

  // Position of a store address inside its frame.
  function automatic int unsigned frame_pos(input int unsigned addr,
                                            input int unsigned fbytes);
    return addr % fbytes;
  endfunction

  // True when a byte violates the fixed head/tail field of its frame.
  function automatic logic const_field_bad(input int unsigned addr,
                                           input int unsigned fbytes,
                                           input logic [7:0] d,
                                           input logic [7:0] head,
                                           input logic [7:0] tail);
    int unsigned p;
    p = frame_pos(addr, fbytes);
    if (p == 0 && d != head) return 1'b1;
    if (p == fbytes - 1 && d != tail) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/cfgld_arm.sv
module cfgld_arm #(
  parameter int OSC_TICKS = 2,
  localparam int TW = $clog2(OSC_TICKS + 1)
) (
  input  logic clk,
  input  logic prog_n,
  input  logic qual,
  input  logic init_i,
  input  logic osc_tick_i,
  output logic armed,
  output logic arm_evt
);

  logic [TW-1:0] ticks;

  assign arm_evt = !armed && qual && init_i && osc_tick_i &&
                   (ticks == TW'(OSC_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      ticks <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (qual && init_i) begin
        if (osc_tick_i) begin
          if (arm_evt) armed <= 1'b1;
          else         ticks <= ticks + 1'b1;
        end
      end else begin
        ticks <= '0;
      end
    end
  end

endmodule

// File: rtl/cfgld_capture.sv
module cfgld_capture #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          prog_n,
  input  logic          enable,
  input  logic          sel_i,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          full,
  output logic          primed
);

  logic accept;
  logic last_slot;

  assign accept    = enable && sel_i && !full;
  assign wr_en     = accept && primed;
  assign last_slot = (wr_addr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!prog_n) begin
      wr_addr <= '0;
      full    <= 1'b0;
      primed  <= 1'b0;
    end else if (accept) begin
      if (!primed) begin
        primed <= 1'b1;
      end else if (last_slot) begin
        full <= 1'b1;
      end else begin
        wr_addr <= wr_addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgld_framechk.sv
module cfgld_framechk
  import cfgld_pkg::*;
#(
  parameter int          DEPTH       = 32,
  parameter int          FRAME_BYTES = 8,
  parameter logic [7:0]  HEAD_BYTE   = 8'hA5,
  parameter logic [7:0]  TAIL_BYTE   = 8'h5A,
  localparam int         AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          prog_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wdata,
  output logic          err
);

  logic bad_byte;

  assign bad_byte = wr_en &&
                    const_field_bad(int'(wr_addr), FRAME_BYTES, wdata,
                                    HEAD_BYTE, TAIL_BYTE);

  always_ff @(posedge clk) begin
    if (!prog_n)       err <= 1'b0;
    else if (bad_byte) err <= 1'b1;
  end

endmodule

// File: rtl/cfgld_store.sv
module cfgld_store #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/chain_cfg_loader.sv
module chain_cfg_loader
  import cfgld_pkg::*;
#(
  parameter int         FRAMES      = 4,
  parameter int         FRAME_BYTES = 8,
  parameter logic [7:0] HEAD_BYTE   = 8'hA5,
  parameter logic [7:0] TAIL_BYTE   = 8'h5A,
  parameter int         OSC_TICKS   = 2,
  parameter bit         DONE_PULLUP = 1'b1,
  localparam int        DEPTH       = FRAMES * FRAME_BYTES,
  localparam int        AW          = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          prog_n,
  input  logic [2:0]    mode_i,
  input  logic          init_i,
  input  logic          osc_tick_i,
  input  logic          sel_i,
  input  logic [7:0]    data_i,
  input  logic          done_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          status_o,
  output logic          done_low_o,
  output logic          done_pu_en_o,
  output logic          active_o,
  output logic          frame_err_o
);

  // Named internal events, visible to the bound checker.
  logic          qual;
  logic          armed;
  logic          arm_evt;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          full;
  logic          primed;

  assign qual = mode_ok(mode_i);

  cfgld_arm #(.OSC_TICKS(OSC_TICKS)) u_arm (
    .clk        (clk),
    .prog_n     (prog_n),
    .qual       (qual),
    .init_i     (init_i),
    .osc_tick_i (osc_tick_i),
    .armed      (armed),
    .arm_evt    (arm_evt)
  );

  cfgld_capture #(.DEPTH(DEPTH)) u_cap (
    .clk     (clk),
    .prog_n  (prog_n),
    .enable  (qual && armed),
    .sel_i   (sel_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .full    (full),
    .primed  (primed)
  );

  cfgld_framechk #(
    .DEPTH(DEPTH), .FRAME_BYTES(FRAME_BYTES),
    .HEAD_BYTE(HEAD_BYTE), .TAIL_BYTE(TAIL_BYTE)
  ) u_chk_frame (
    .clk     (clk),
    .prog_n  (prog_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wdata   (data_i),
    .err     (frame_err_o)
  );

  cfgld_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (data_i),
    .raddr (rd_addr_i),
    .rdata (rd_data_o)
  );

  // Wired-AND start: wait for the shared done line after own fill.
  always_ff @(posedge clk) begin
    if (!prog_n)              active_o <= 1'b0;
    else if (full && done_i)  active_o <= 1'b1;
  end

  assign status_o     = !armed || full;
  assign done_low_o   = !full;
  assign done_pu_en_o = DONE_PULLUP;

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          prog_n,
  input logic [2:0]    mode_i,
  input logic          sel_i,
  input logic          done_i,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          full,
  input logic          armed,
  input logic          status_o,
  input logic          done_low_o,
  input logic          active_o,
  input logic          frame_err_o
);

  p_mode_gate_r1: assert property (@(posedge clk) disable iff (!prog_n)
    (mode_i != 3'b010) |-> !wr_en);

  p_status_idle_r2: assert property (@(posedge clk) disable iff (!prog_n)
    !armed |-> status_o);

  p_sel_gate_r3: assert property (@(posedge clk) disable iff (!prog_n)
    wr_en |-> (sel_i && armed));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!prog_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == AW'($past(wr_addr) + 1'b1)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!prog_n)
    full |-> (!wr_en && status_o));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!prog_n)
    frame_err_o |=> frame_err_o);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!prog_n)
    !armed |-> done_low_o);

  p_active_sticky_r8: assert property (@(posedge clk) disable iff (!prog_n)
    active_o |=> active_o);

  p_active_cause_r8: assert property (@(posedge clk) disable iff (!prog_n)
    $rose(active_o) |-> ($past(done_i) && $past(full)));

endmodule

bind chain_cfg_loader cfgld_checker #(.AW(AW)) u_cfgld_checker (
  .clk         (clk),
  .prog_n      (prog_n),
  .mode_i      (mode_i),
  .sel_i       (sel_i),
  .done_i      (done_i),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .full        (full),
  .armed       (armed),
  .status_o    (status_o),
  .done_low_o  (done_low_o),
  .active_o    (active_o),
  .frame_err_o (frame_err_o)
);

// File: tb/chain_cfg_loader_test.sv
module chain_cfg_loader_test;

  localparam int         FB    = 8;
  localparam int         NFR   = 4;
  localparam int         DEPTH = FB * NFR;
  localparam int         AW    = $clog2(DEPTH);
  localparam logic [7:0] HEAD  = 8'hA5;
  localparam logic [7:0] TAIL  = 8'h5A;

  logic          clk = 1'b0;
  logic          prog_n = 1'b0;
  logic [2:0]    mode_i = 3'b000;
  logic          init_i = 1'b0;
  logic          osc_tick_i = 1'b0;
  logic          sel_i = 1'b0;
  logic [7:0]    data_i = 8'h00;
  logic          done_i = 1'b0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;
  logic          status_o, done_low_o, done_pu_en_o, active_o, frame_err_o;

  always #2 clk = ~clk;

  chain_cfg_loader uut (
    .clk(clk), .prog_n(prog_n), .mode_i(mode_i), .init_i(init_i),
    .osc_tick_i(osc_tick_i), .sel_i(sel_i), .data_i(data_i), .done_i(done_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .status_o(status_o),
    .done_low_o(done_low_o), .done_pu_en_o(done_pu_en_o),
    .active_o(active_o), .frame_err_o(frame_err_o)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit started = 1'b0;

  // Behavioural reference model
  int         m_ticks = 0, m_cnt = 0;
  bit         m_armed = 0, m_primed = 0, m_full = 0, m_err = 0, m_active = 0;
  logic [7:0] m_mem [DEPTH];
  bit         m_valid [DEPTH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(posedge clk) begin
    bit f0;
    cyc++;
    rd_addr_i <= rd_addr_i + 1'b1;
    f0 = m_full;
    if (!prog_n) begin
      m_ticks = 0; m_cnt = 0; m_armed = 0; m_primed = 0;
      m_full = 0; m_err = 0; m_active = 0;
    end else begin
      if (!m_armed) begin
        if (mode_i == 3'b010 && init_i) begin
          if (osc_tick_i) begin
            if (m_ticks == 1) m_armed = 1;
            else m_ticks++;
          end
        end else m_ticks = 0;
      end else if (mode_i == 3'b010 && sel_i && !m_full) begin
        if (!m_primed) m_primed = 1;
        else begin
          m_mem[m_cnt] = data_i;
          m_valid[m_cnt] = 1;
          if ((m_cnt % FB == 0 && data_i != HEAD) ||
              (m_cnt % FB == FB - 1 && data_i != TAIL)) m_err = 1;
          m_cnt++;
          if (m_cnt == DEPTH) m_full = 1;
        end
      end
      if (f0 && done_i) m_active = 1;
    end
    if (cyc > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired (all requirements) act=%0d exp<=20000", cyc);
      summary();
      $finish;
    end
  end

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      chk("R2 status_o",     status_o,    (!m_armed) || m_full);
      chk("R7 done_low_o",   done_low_o,  !m_full);
      chk("R8 active_o",     active_o,    m_active);
      chk("R6 frame_err_o",  frame_err_o, m_err);
      chk("R10 done_pu_en_o", done_pu_en_o, 1'b1);
      if (m_valid[rd_addr_i]) chk("R4 rd_data_o", rd_data_o, m_mem[rd_addr_i]);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic arm_seq(bit drop_init);
    init_i = 1'b1;
    osc_tick_i = 1'b1; step(1);
    osc_tick_i = 1'b0; step(1);
    if (drop_init) begin
      init_i = 1'b0; step(1);
      init_i = 1'b1;
      osc_tick_i = 1'b1; step(1);
      osc_tick_i = 1'b0; step(1);
      chk("R2 still high after init drop", status_o, 1'b1);
    end
    osc_tick_i = 1'b1; step(1);
    osc_tick_i = 1'b0;
    #1 chk("R2 low after second tick", status_o, 1'b0);
  endtask

  function automatic logic [7:0] frame_byte(int i, int bad_at);
    logic [7:0] b;
    if (i % FB == 0)           b = HEAD;
    else if (i % FB == FB - 1) b = TAIL;
    else                       b = 8'(i * 7 + 3);
    if (i == bad_at) b = b ^ 8'h10;
    return b;
  endfunction

  task automatic pulse_prog();
    prog_n = 1'b0; step(1);
    prog_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 0;
    step(1);
    started = 1'b1;
    step(2);
    // R9 reset state
    chk("R9 status after program", status_o, 1'b1);
    chk("R9 done_low after program", done_low_o, 1'b1);
    chk("R9 active after program", active_o, 1'b0);
    chk("R9 err after program", frame_err_o, 1'b0);
    chk("R10 pull-up default", done_pu_en_o, 1'b1);
    prog_n = 1'b1;

    // R1: wrong mode never arms
    mode_i = 3'b011; init_i = 1'b1; sel_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      osc_tick_i = ~osc_tick_i; data_i = 8'(i); step(1);
    end
    osc_tick_i = 1'b0;
    chk("R1 status stays high in other mode", status_o, 1'b1);

    // Load 1: good frames, init drop during count, sel low bytes ignored
    pulse_prog();
    mode_i = 3'b010; sel_i = 1'b0; init_i = 1'b0; step(1);
    arm_seq(1'b1);
    for (int i = 0; i < 3; i++) begin data_i = 8'hEE; step(1); end  // R3
    sel_i = 1'b1; data_i = 8'hCC; step(1);                          // R4 setup edge
    for (int i = 0; i < DEPTH; i++) begin data_i = frame_byte(i, -1); step(1); end
    for (int i = 0; i < 4; i++) begin data_i = 8'h77; step(1); end  // R5 ignored
    chk("R5 status high when full", status_o, 1'b1);
    chk("R6 no error on good frames", frame_err_o, 1'b0);
    step(3);
    chk("R8 waits for shared done", active_o, 1'b0);
    done_i = 1'b1; step(1);
    chk("R8 active after done high", active_o, 1'b1);
    step(DEPTH);  // read port scans the kept contents

    // Load 2: bad tail, sel gap mid-frame, done floating high
    pulse_prog();
    chk("R9 active cleared", active_o, 1'b0);
    sel_i = 1'b0; init_i = 1'b0; step(1);
    arm_seq(1'b0);
    sel_i = 1'b1; data_i = 8'h00; step(1);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 12) begin sel_i = 1'b0; data_i = 8'hBB; step(2); sel_i = 1'b1; end
      data_i = frame_byte(i, 15); step(1);
    end
    chk("R6 error on bad tail", frame_err_o, 1'b1);
    step(1);
    chk("R8 active with floating done", active_o, 1'b1);
    step(DEPTH);

    pulse_prog();
    #1 chk("R9 error cleared", frame_err_o, 1'b0);
    step(2);
    summary();
    $finish;
  end

endmodule